// File: doc/BRIEF.md
# Clock Recovery Lock Monitor

This block supervises a serial clock-recovery loop. It receives, in a single system clock domain, a pulse for each reference-clock period (`ref_tick`) and a pulse for each recovered bit (`rec_tick`). It also receives a flag that marks recovered bits carrying a data transition (`data_edge`). From these it decides whether the loop may follow the incoming data or must fall back to the reference. It reports that decision on an active-low lock output and on a source-select output.

Frequency offset is judged by counting recovered ticks over a fixed window of reference ticks. With the default of 8192 reference ticks, one count of difference is about 122 ppm. A locked loop tolerates up to 4 counts and drops lock at 5 or more. An unlocked loop regains lock at 3 counts or fewer. The count of 4 lies between the two thresholds, so it keeps whatever state the loop is already in.

A watchdog on the transition density drops lock when too many recovered bits pass without a transition. After reset, the block waits for the first transition and then judges a short acquisition window. With the default of 256 reference ticks at 125 MHz, that window lasts about 2 µs, so lock is reported well inside 2.5 µs.

Top module: `cdr_lock_monitor`

## Requirements
- R1: After reset, `lock_n` and `track_ref` are both 1. No window is counted until the first cycle with `data_edge` high. Before that cycle, ticks alone never produce lock.
- R2: The first window after reset begins in the cycle of the first transition and spans ACQ_TICKS reference ticks. It grants lock if the absolute difference between recovered ticks and reference ticks is at most ACQ_TOL (1). Otherwise the block stays unlocked and judges another short window immediately after.
- R3: While locked, a long window (WIN_TICKS reference ticks) whose absolute count difference is at most 2 keeps lock. This holds whether the recovered clock is faster or slower than the reference.
- R4: While locked, a long window with a difference above LOSE_OVER (4) drops lock. A difference of exactly 4 keeps lock.
- R5: While unlocked after a loss, a long window with a difference at most REGAIN_MAX (3) restores lock. Differences of 4 and 6 leave the block unlocked.
- R6: A phase step in the data pattern, with a single-tick change in the window count, does not cause a loss of lock.
- R7: While locked, lock is dropped on the clock edge that ends the RUN_LIMIT-th (default 128) consecutive recovered bit without a transition. A run of RUN_LIMIT-1 such bits keeps lock. The window restarts at that point.
- R8: `lock_n` = 0 means the loop follows the data. Whenever `lock_n` = 1, `track_ref` = 1 selects the reference clock. Both outputs change on the clock edge after the cycle that decides them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One pulse per reference-clock period |
| rec_tick | input | 1 | One pulse per recovered bit |
| data_edge | input | 1 | Recovered bit carries a data transition |
| lock_n | output | 1 | Active-low lock to incoming data |
| track_ref | output | 1 | 1 = loop tracks the reference clock |

## Verification
The hardest state to reach is the band between the two thresholds, a difference of exactly 4 counts. It must be met once while locked and once while unlocked, and the two must give opposite verdicts.

The bench steers there by building every window from a known number of missing reference ticks and missing recovered ticks. This fixes the count difference and its sign exactly. It then orders the windows so that the same difference arrives in each state.

The transition watchdog needs the edge pattern of the preceding window to be known. That pattern leaves three edge-free bits at the window end, so a quiet stretch of 124 and then 1 further bit lands on both sides of the limit.

// File: rtl/cdr_lock_monitor.sv
module cdr_lock_monitor #(
  parameter int WIN_TICKS  = 8192,
  parameter int ACQ_TICKS  = 256,
  parameter int ACQ_TOL    = 1,
  parameter int LOSE_OVER  = 4,
  parameter int REGAIN_MAX = 3,
  parameter int RUN_LIMIT  = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic rec_tick,
  input  logic data_edge,
  output logic lock_n,
  output logic track_ref
);
  localparam int CW = $clog2(2 * WIN_TICKS) + 1;
  localparam int RW = $clog2(RUN_LIMIT + 1);

  typedef enum logic [1:0] {ST_ACQ, ST_DATA, ST_REF} st_t;

  st_t          st;
  logic         armed;
  logic [CW-1:0] ref_cnt, rec_cnt;
  logic [RW-1:0] run_cnt;

  wire          counting  = armed | data_edge | (st != ST_ACQ);
  wire [CW-1:0] win_len   = (st == ST_ACQ) ? CW'(ACQ_TICKS) : CW'(WIN_TICKS);
  wire          win_end   = counting & ref_tick & (ref_cnt == win_len - CW'(1));
  wire [CW-1:0] rec_total = rec_cnt + CW'(rec_tick);
  wire [CW-1:0] diff      = (rec_total >= win_len) ? rec_total - win_len
                                                   : win_len - rec_total;
  wire          run_hit   = (st == ST_DATA) & rec_tick & ~data_edge &
                            (run_cnt == RW'(RUN_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_ACQ;
      armed   <= 1'b0;
      ref_cnt <= '0;
      rec_cnt <= '0;
    end else begin
      if (data_edge) armed <= 1'b1;
      if (run_hit) begin
        st      <= ST_REF;
        ref_cnt <= '0;
        rec_cnt <= '0;
      end else if (win_end) begin
        ref_cnt <= '0;
        rec_cnt <= '0;
        case (st)
          ST_ACQ:  if (diff <= CW'(ACQ_TOL))    st <= ST_DATA;
          ST_DATA: if (diff >  CW'(LOSE_OVER))  st <= ST_REF;
          ST_REF:  if (diff <= CW'(REGAIN_MAX)) st <= ST_DATA;
          default: st <= ST_ACQ;
        endcase
      end else if (counting) begin
        ref_cnt <= ref_cnt + CW'(ref_tick);
        if (rec_tick && rec_cnt != '1) rec_cnt <= rec_cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st != ST_DATA || data_edge) run_cnt <= '0;
    else if (rec_tick)                        run_cnt <= run_cnt + RW'(1);
  end

  assign lock_n    = (st != ST_DATA);
  assign track_ref = lock_n;
endmodule

module cdr_lock_monitor_chk #(
  parameter int WIN_TICKS = 8192,
  parameter int RUN_LIMIT = 128,
  parameter int CW        = 15,
  parameter int RW        = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_tick,
  input logic          rec_tick,
  input logic          data_edge,
  input logic          lock_n,
  input logic [CW-1:0] ref_cnt,
  input logic [RW-1:0] run_cnt
);
  AST_LOCK_ONLY_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(lock_n) |-> $past(ref_tick)); // R2
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n) ref_cnt < CW'(WIN_TICKS)); // R3
  AST_RUN_LIMIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (!lock_n && rec_tick && !data_edge && run_cnt == RW'(RUN_LIMIT - 1)) |=> lock_n); // R7
  AST_EDGE_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (!lock_n && data_edge && !ref_tick) |=> !lock_n); // R6
endmodule

bind cdr_lock_monitor cdr_lock_monitor_chk #(
  .WIN_TICKS(WIN_TICKS), .RUN_LIMIT(RUN_LIMIT), .CW(CW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rec_tick(rec_tick),
  .data_edge(data_edge), .lock_n(lock_n), .ref_cnt(ref_cnt), .run_cnt(run_cnt)
);

// File: tb/cdr_lock_monitor_tb.sv
module cdr_lock_monitor_tb;
  localparam int WIN = 8192;
  localparam int ACQ = 256;
  localparam int RUN = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_tick = 1'b0, rec_tick = 1'b0, data_edge = 1'b0;
  logic lock_n, track_ref;

  always #5 clk = ~clk;

  cdr_lock_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rec_tick(rec_tick),
    .data_edge(data_edge), .lock_n(lock_n), .track_ref(track_ref)
  );

  typedef struct { logic lk; logic tr; int due; string tag; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (lock_n !== it.lk || track_ref !== it.tr) begin
        errors++;
        $display("FAIL %s: lock_n=%b track_ref=%b expected lock_n=%b track_ref=%b",
                 it.tag, lock_n, track_ref, it.lk, it.tr);
      end
    end
  end

  task automatic expect_out(logic lk, logic tr, string tag);
    item_t it;
    it.lk = lk; it.tr = tr; it.tag = tag; it.due = cyc + 1;
    q.push_back(it);
  endtask

  // difference of the window = gaps - drops
  task automatic run_window(int len, int gaps, int drops, int off);
    int refs = 0;
    int i = 0;
    while (refs < len) begin
      @(negedge clk);
      ref_tick  = !((i % 4 == 1) && (i / 4 < gaps));
      rec_tick  = !((i % 4 == 2) && (i / 4 < drops));
      data_edge = ((i + off) % 4 == 0);
      if (ref_tick) refs++;
      i++;
    end
  endtask

  task automatic quiet(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ref_tick = 1'b1; rec_tick = 1'b1; data_edge = 1'b0;
    end
  endtask

  initial begin
    #1_500_000ns;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    quiet(40);
    expect_out(1'b1, 1'b1, "R1 unlocked with ticks but no transition");
    run_window(ACQ, 0, 2, 0);
    expect_out(1'b1, 1'b1, "R2 acquisition rejected at 2 counts");
    run_window(ACQ, 0, 0, 0);
    expect_out(1'b0, 1'b0, "R2 lock after short window");
    run_window(WIN, 0, 2, 0);
    expect_out(1'b0, 1'b0, "R3 slow by 2 keeps lock");
    run_window(WIN, 2, 0, 0);
    expect_out(1'b0, 1'b0, "R3 fast by 2 keeps lock");
    run_window(WIN, 4, 0, 0);
    expect_out(1'b0, 1'b0, "R4 band of 4 keeps lock");
    run_window(WIN, 0, 5, 0);
    expect_out(1'b1, 1'b1, "R4 R8 loss at 5 selects reference");
    run_window(WIN, 4, 0, 0);
    expect_out(1'b1, 1'b1, "R5 band of 4 stays unlocked");
    run_window(WIN, 0, 6, 0);
    expect_out(1'b1, 1'b1, "R5 6 counts no regain");
    run_window(WIN, 3, 0, 0);
    expect_out(1'b0, 1'b0, "R5 regain at 3");
    run_window(WIN, 1, 0, 2);
    expect_out(1'b0, 1'b0, "R6 phase step tolerated");
    run_window(WIN, 0, 0, 0);
    expect_out(1'b0, 1'b0, "R3 clean window keeps lock");
    quiet(RUN - 4);
    expect_out(1'b0, 1'b0, "R7 run of 127 bits keeps lock");
    quiet(1);
    expect_out(1'b1, 1'b1, "R7 R8 run of 128 bits drops lock");
    run_window(WIN, 0, 0, 0);
    expect_out(1'b0, 1'b0, "R5 regain after run-length loss");
    quiet(4);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule